// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns parallel characters from a host into an asynchronous serial stream. It holds two characters at once. A holding register takes a new character from the host while a shift register sends the one before it, so the host can reload while a frame is still on the line. Each frame is a low start bit, then the data least significant bit first, then an optional parity bit, then one or more high stop bits.

The frame format comes from a set of framing inputs:
- word length of 5 to 8 bits;
- parity enable, with odd, even or stick selection;
- a stop-length select that gives 1, 1.5 or 2 stop bits.

The shifter captures these settings when a character enters it. A separate break input pulls the serial line low and leaves the shifter running, so the host can time a break in whole character periods.

The block is driven by a 16x oversampling baud tick. It reports two flags: holding empty, and transmitter empty (nothing left to send). The divisor that makes the tick and any host register decode sit outside the block.

Top module: `sertx_framer`

## Requirements
- R1: After reset, `txd_o` is 1, `hold_empty_o` is 1 and `tx_empty_o` is 1. While nothing is being sent and `brk_i` is 0, `txd_o` stays at 1.
- R2: Every bit lasts OVS ticks of `tick_i`. A frame starts with a 0 start bit, followed by the data bits from bit 0 upward. The number of data bits is 5 + `wlen_i`: code 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the word length are not sent.
- R3: When `par_en_i` is 1, one parity bit follows the last data bit. With `par_even_i` = 1 the parity bit makes the count of ones in data plus parity even. With `par_even_i` = 0 it makes that count odd.
- R4: When `par_en_i` and `par_stick_i` are both 1, the parity bit is the inverse of `par_even_i`, whatever the data.
- R5: With `stop2_i` = 0 there is one stop bit at level 1. With `stop2_i` = 1 and `wlen_i` = 0 the stop time is 1.5 bits (OVS + OVS/2 ticks). With `stop2_i` = 1 and any other word length it is two bits.
- R6: While `brk_i` is 1, `txd_o` is 0, one clock after `brk_i` is sampled. The flags and the frame timing stay exactly as they would be without break.
- R7: A write makes `hold_empty_o` go to 0 on the next clock. When the shifter is idle, the character moves into the shifter at the first tick after the write, and `hold_empty_o` returns to 1 in that cycle.
- R8: `tx_empty_o` is 0 from the write until the tick that ends the last stop bit, and is 1 only when both registers are empty.
- R9: If a character is waiting in the holding register when a stop period ends, its start bit follows on the very next tick with no idle time, and `hold_empty_o` rises at that tick.
- R10: The framing inputs are sampled when a character enters the shifter. Changing them during the frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick_i | input | 1 | Oversampling baud tick, one clock wide |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Character, right justified |
| wlen_i | input | 2 | Word length code (5 + code bits) |
| stop2_i | input | 1 | Long stop select |
| par_en_i | input | 1 | Parity enable |
| par_even_i | input | 1 | Even parity select |
| par_stick_i | input | 1 | Stick parity select |
| brk_i | input | 1 | Break: force serial line low |
| txd_o | output | 1 | Serial output |
| hold_empty_o | output | 1 | Holding register empty |
| tx_empty_o | output | 1 | Holding and shift registers both empty |

## Verification
The bench builds the block with OVS = 16, the minimum word length of 5 and a registered output with stick parity present. With OVS = 16 the half stop bit is 8 ticks, so the 1.5-stop case can be told apart from the one- and two-stop cases.

Ticks come every four clocks. This leaves space to place host writes away from tick edges, so back-to-back loading and loading from idle can each be reached on purpose.

A tick-counting monitor samples each bit at its centre. It checks the tick count from load to transmitter empty against the frame length computed from the requirements. The stimulus is every word length with every parity mode, a random sweep, and the break case with the mid-frame format change.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      SX_IDLE,
      SX_START,
      SX_DATA,
      SX_PAR,
      SX_STOP
   } sx_state_e;

   typedef struct packed {
      logic [1:0] wlen;
      logic       stop2;
      logic       par_en;
      logic       par_even;
      logic       par_stick;
   } sx_fmt_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              take_i,
   output logic [DATA_W-1:0] data_o,
   output logic              empty_o
);

   logic              full_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else begin
         full_q <= (full_q & ~take_i) | wr_i;
         if (wr_i) data_q <= data_i;
      end
   end

   assign data_o  = data_q;
   assign empty_o = ~full_q;

   // R7
   wr_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> !empty_o);

   // R7
   empty_by_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(empty_o) |-> $past(take_i));

endmodule

// File: rtl/sertx_parity.sv
module sertx_parity #(
   parameter int DATA_W   = 8,
   parameter int MIN_BITS = 5,
   parameter bit STICK_EN = 1'b1
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [1:0]        wlen_i,
   input  logic              even_i,
   input  logic              stick_i,
   output logic              par_o
);

   logic [DATA_W-1:0] keep;
   logic              ones_odd;

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign keep[i] = (({30'd0, wlen_i} + MIN_BITS) > i);
   end

   assign ones_odd = ^(data_i & keep);

   if (STICK_EN) begin : g_stick
      assign par_o = stick_i ? ~even_i : (even_i ? ones_odd : ~ones_odd);
   end else begin : g_nostick
      logic unused_stick;
      assign unused_stick = stick_i;
      assign par_o = even_i ? ones_odd : ~ones_odd;
   end

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MIN_BITS = 5,
   parameter int OVS      = 16,
   parameter bit STICK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  sx_fmt_t           fmt_i,
   input  logic              hold_full_i,
   input  logic [DATA_W-1:0] hold_data_i,
   output logic              take_o,
   output logic              line_o,
   output logic              idle_o
);

   localparam int CW   = $clog2(2 * OVS);
   localparam int IW   = $clog2(DATA_W);
   localparam int HALF = OVS / 2;

   sx_state_e         state_q;
   logic [CW-1:0]     tcnt_q;
   logic [IW-1:0]     bidx_q;
   logic [DATA_W-1:0] sh_q;
   sx_fmt_t           fmt_q;
   logic              par_q;
   logic              par_new;
   logic [CW-1:0]     stop_last;
   logic [IW-1:0]     last_idx;
   logic              bit_end;

   sertx_parity #(
      .DATA_W  (DATA_W),
      .MIN_BITS(MIN_BITS),
      .STICK_EN(STICK_EN)
   ) i_par (
      .data_i (hold_data_i),
      .wlen_i (fmt_i.wlen),
      .even_i (fmt_i.par_even),
      .stick_i(fmt_i.par_stick),
      .par_o  (par_new)
   );

   always_comb begin
      if (!fmt_q.stop2)           stop_last = CW'(OVS - 1);
      else if (fmt_q.wlen == 2'd0) stop_last = CW'(OVS + HALF - 1);
      else                        stop_last = CW'(2 * OVS - 1);
   end

   assign last_idx = IW'(MIN_BITS - 1) + IW'(fmt_q.wlen);
   assign bit_end  = (state_q == SX_STOP) ? (tcnt_q == stop_last)
                                          : (tcnt_q == CW'(OVS - 1));
   assign take_o   = tick_i & hold_full_i &
                     ((state_q == SX_IDLE) | ((state_q == SX_STOP) & bit_end));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SX_IDLE;
         tcnt_q  <= '0;
         bidx_q  <= '0;
         sh_q    <= '0;
         fmt_q   <= '0;
         par_q   <= 1'b0;
      end else if (take_o) begin
         state_q <= SX_START;
         tcnt_q  <= '0;
         bidx_q  <= '0;
         sh_q    <= hold_data_i;
         fmt_q   <= fmt_i;
         par_q   <= par_new;
      end else if (tick_i && state_q != SX_IDLE) begin
         if (!bit_end) begin
            tcnt_q <= tcnt_q + 1'b1;
         end else begin
            tcnt_q <= '0;
            unique case (state_q)
               SX_START: state_q <= SX_DATA;
               SX_DATA: begin
                  sh_q   <= sh_q >> 1;
                  bidx_q <= bidx_q + 1'b1;
                  if (bidx_q == last_idx)
                     state_q <= fmt_q.par_en ? SX_PAR : SX_STOP;
               end
               SX_PAR:  state_q <= SX_STOP;
               default: state_q <= SX_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      unique case (state_q)
         SX_START: line_o = 1'b0;
         SX_DATA:  line_o = sh_q[0];
         SX_PAR:   line_o = par_q;
         default:  line_o = 1'b1;
      endcase
   end

   assign idle_o = (state_q == SX_IDLE);

   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |=> (line_o == 1'b0));

   // R2
   bit_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SX_DATA) |-> (bidx_q <= last_idx));

   // R10
   fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_o && !take_o) |=> $stable(fmt_q));

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
   import sertx_pkg::*;
#(
   parameter int MIN_BITS = 5,
   parameter int OVS      = 16,
   parameter bit OUT_REG  = 1'b1,
   parameter bit STICK_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_i,
   input  logic                  wr_i,
   input  logic [MIN_BITS+2:0]   wr_data_i,
   input  logic [1:0]            wlen_i,
   input  logic                  stop2_i,
   input  logic                  par_en_i,
   input  logic                  par_even_i,
   input  logic                  par_stick_i,
   input  logic                  brk_i,
   output logic                  txd_o,
   output logic                  hold_empty_o,
   output logic                  tx_empty_o
);

   localparam int DATA_W = MIN_BITS + 3;

   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("sertx_framer: OVS must be even and at least 4");
   end
   if (MIN_BITS < 2) begin : g_bad_min
      $error("sertx_framer: MIN_BITS must be at least 2");
   end

   sx_fmt_t           fmt;
   logic              take;
   logic              line;
   logic              sh_idle;
   logic              h_empty;
   logic [DATA_W-1:0] h_data;

   assign fmt = '{wlen: wlen_i, stop2: stop2_i, par_en: par_en_i,
                  par_even: par_even_i, par_stick: par_stick_i};

   sertx_hold #(.DATA_W(DATA_W)) i_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (wr_i),
      .data_i (wr_data_i),
      .take_i (take),
      .data_o (h_data),
      .empty_o(h_empty)
   );

   sertx_shift #(
      .DATA_W  (DATA_W),
      .MIN_BITS(MIN_BITS),
      .OVS     (OVS),
      .STICK_EN(STICK_EN)
   ) i_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .fmt_i      (fmt),
      .hold_full_i(~h_empty),
      .hold_data_i(h_data),
      .take_o     (take),
      .line_o     (line),
      .idle_o     (sh_idle)
   );

   assign hold_empty_o = h_empty;
   assign tx_empty_o   = h_empty & sh_idle;

   if (OUT_REG) begin : g_oreg
      logic txd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) txd_q <= 1'b1;
         else        txd_q <= line & ~brk_i;
      end
      assign txd_o = txd_q;

      // R6
      brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         brk_i |=> (txd_o == 1'b0));

      // R1
      idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_empty_o && !brk_i) |=> txd_o);
   end else begin : g_ocomb
      assign txd_o = line & ~brk_i;

      // R6
      brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         brk_i |-> (txd_o == 1'b0));

      // R1
      idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (tx_empty_o && !brk_i) |-> txd_o);
   end

   // R8
   empty_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i) |=> !tx_empty_o);

endmodule

// File: tb/test_sertx_framer.sv
module test_sertx_framer;

   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int OVS        = 16;
   localparam int WDOG       = 180000;

   typedef struct {
      logic [7:0] d;
      logic [1:0] wl;
      logic       s2, pe, ev, st;
      string      tag;
   } ent_t;

   logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
   logic [7:0] wd = '0;
   logic [1:0] wlen = 2'd3;
   logic       stop2 = 1'b0, pe = 1'b0, ev = 1'b0, st = 1'b0, brk = 1'b0;
   logic       txd, he, te;
   string      cur_tag = "";
   ent_t       q[$];
   int         n_chk = 0, n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sertx_framer #(.MIN_BITS(5), .OVS(OVS), .OUT_REG(1'b1), .STICK_EN(1'b1)) i_sertx_framer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_i(wr), .wr_data_i(wd),
      .wlen_i(wlen), .stop2_i(stop2), .par_en_i(pe), .par_even_i(ev),
      .par_stick_i(st), .brk_i(brk), .txd_o(txd), .hold_empty_o(he),
      .tx_empty_o(te)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic par_bit(input ent_t e);
      logic x = 1'b0;
      for (int i = 0; i < 5 + int'(e.wl); i++) x ^= e.d[i];
      if (e.st) return ~e.ev;
      return e.ev ? x : ~x;
   endfunction

   // tick generator: high for one clock every TICK_DIV clocks
   initial begin
      forever begin
         repeat (TICK_DIV - 1) @(posedge clk);
         #1 tick = 1'b1;
         @(posedge clk);
         #1 tick = 1'b0;
      end
   end

   task automatic write_char(input logic [7:0] d);
      ent_t e;
      @(posedge clk); #2;
      while (tick) begin @(posedge clk); #2; end
      e.d = d; e.wl = wlen; e.s2 = stop2; e.pe = pe; e.ev = ev; e.st = st;
      e.tag = cur_tag;
      wd = d; wr = 1'b1;
      q.push_back(e);
      @(posedge clk); #2 wr = 1'b0;
   endtask

   task automatic wait_he();
      do @(negedge clk); while (!he);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!(te && q.size() == 0));
      repeat (2) @(negedge clk);
   endtask

   // frame monitor: counts ticks from load, samples bit centres
   initial begin
      logic prv, nxt;
      ent_t e;
      logic lvl [16];
      string tg [16];
      int nb, f, n, cnt;
      bit half;
      prv = 1'b1; nxt = 1'b0;
      @(posedge rst_n);
      forever begin
         if (!nxt) begin
            forever begin
               @(negedge clk);
               if (he && !prv) break;
               prv = he;
            end
         end
         if (q.size() == 0) begin
            chk(1'b0, "R7 spurious load", 1, 0);
            prv = he; nxt = 1'b0;
            continue;
         end
         e = q.pop_front();
         nb = 5 + int'(e.wl);
         lvl[0] = 1'b0; tg[0] = "R2 start";
         for (int i = 0; i < nb; i++) begin lvl[1+i] = e.d[i]; tg[1+i] = "R2 data"; end
         f = 1 + nb;
         if (e.pe) begin
            lvl[f] = par_bit(e);
            tg[f] = e.st ? "R4 stick parity" : "R3 parity";
            f++;
         end
         lvl[f] = 1'b1; tg[f] = "R5 stop"; f++;
         half = e.s2 && (e.wl == 2'd0);
         if (e.s2 && !half) begin lvl[f] = 1'b1; tg[f] = "R5 stop2"; f++; end
         n = OVS * f + (half ? OVS/2 : 0);
         cnt = 0;
         while (cnt < n) begin
            @(negedge clk);
            if (tick) begin
               cnt++;
               for (int k = 0; k < f; k++) begin
                  if (cnt == OVS*k + OVS/2) begin
                     if (brk) chk(txd == 1'b0, "R6 break", txd, 0);
                     else if (e.tag != "") chk(txd == lvl[k], e.tag, txd, lvl[k]);
                     else chk(txd == lvl[k], tg[k], txd, lvl[k]);
                  end
               end
               if (half && cnt == OVS*f + OVS/4)
                  chk(txd == !brk, "R5 half stop", txd, !brk);
               if (cnt == n) chk(te == 1'b0, "R8 busy until last tick", te, 0);
            end
         end
         @(negedge clk);
         if (q.size() > 0) begin
            chk(he == 1'b1, "R9 back-to-back load", he, 1);
            nxt = 1'b1;
         end else begin
            chk(te == 1'b1, "R8 empty after last stop", te, 1);
            nxt = 1'b0;
         end
         prv = he;
      end
   end

   initial begin
      int cnt;
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(txd == 1'b1, "R1 txd", txd, 1);
      chk(he == 1'b1, "R1 hold_empty", he, 1);
      chk(te == 1'b1, "R1 tx_empty", te, 1);
      repeat (20) @(negedge clk);
      chk(txd == 1'b1, "R1 idle high", txd, 1);

      // R7: load from idle on the first tick after the write
      write_char(8'h55);
      @(negedge clk);
      chk(he == 1'b0, "R7 write clears hold_empty", he, 0);
      chk(te == 1'b0, "R8 write clears tx_empty", te, 0);
      cnt = 0;
      forever begin
         if (he) break;
         if (tick) cnt++;
         @(negedge clk);
      end
      chk(cnt == 1, "R7 ticks until load", cnt, 1);
      wait_idle();

      // R2 R3 R4 R5: every word length, every parity mode, both stop selects
      for (int wl = 0; wl < 4; wl++) begin
         for (int m = 0; m < 5; m++) begin
            wlen = 2'(wl);
            stop2 = 1'(m % 2);
            pe = (m != 0);
            ev = (m == 2) || (m == 4);
            st = (m >= 3);
            write_char(8'($urandom));
            wait_idle();
         end
      end

      // R9: second character queued while the first is shifting
      wlen = 2'd3; stop2 = 1'b0; pe = 1'b1; ev = 1'b0; st = 1'b0;
      write_char(8'hA3);
      wait_he();
      write_char(8'h3C);
      wait_he();
      write_char(8'h81);
      wait_idle();

      // R6: break keeps the line low, timing unchanged
      brk = 1'b1;
      repeat (3) @(negedge clk);
      chk(txd == 1'b0, "R6 break while idle", txd, 0);
      wlen = 2'd0; stop2 = 1'b1; pe = 1'b1; ev = 1'b1; st = 1'b0;
      write_char(8'hFF);
      wait_idle();
      chk(te == 1'b1, "R6 tx_empty under break", te, 1);
      brk = 1'b0;
      repeat (3) @(negedge clk);
      chk(txd == 1'b1, "R6 release break", txd, 1);

      // R10: format change after load does not alter the frame
      wlen = 2'd3; stop2 = 1'b0; pe = 1'b0; ev = 1'b0; st = 1'b0;
      cur_tag = "R10 format sampled at load";
      write_char(8'hC6);
      wait_he();
      @(posedge clk); #2;
      wlen = 2'd0; stop2 = 1'b1; pe = 1'b1; ev = 1'b1; st = 1'b1;
      wait_idle();
      cur_tag = "";

      // random sweep, gaps of zero give back-to-back frames
      for (int r = 0; r < 40; r++) begin
         wait_he();
         if (q.size() == 0 && te) begin
            wlen = 2'($urandom);
            stop2 = 1'($urandom);
            pe = 1'($urandom);
            ev = 1'($urandom);
            st = 1'($urandom);
         end
         repeat ($urandom % 40) @(posedge clk);
         write_char(8'($urandom));
      end
      wait_idle();

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (WDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", WDOG, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule